// File: doc/BRIEF.md
# Backoff-Aware Direct Master Tracker

This block sits between a local bus master and the outbound path of a bridge. It follows one transfer at a time from the local master toward the PCI side. Write beats are handed to an 8-entry write FIFO that drains toward the PCI side. Read beats are fetched from the PCI side into a burst-sized buffer and returned to the master. An external arbiter can take the local bus away in the middle of a transfer so that the bridge can serve an inbound slave access. It does this by raising the bus grant input. On that grant the tracker ends the local access at once, and it never asserts ready while the grant is high.

Work done before the interruption is kept. Write beats already accepted stay queued, and the tracker remembers how many there were. Read beats already fetched stay in the buffer. When the master comes back with a new address strobe that carries the same address and direction, the transfer continues. For a write, the next data taken is the first beat that was not accepted. For a read, delivery resumes from the first beat not yet returned, and nothing is fetched again. A strobe with a different address or direction discards the kept read data and starts a new transfer.

The controller has four states. The transitions are:
- IDLE goes to WRITE or READ on a strobe, following the direction input.
- WRITE and READ go to BACKOFF when the grant is seen.
- WRITE and READ go back to IDLE after the last beat.
- BACKOFF goes to WRITE or READ on a strobe. A matching strobe is a resume; any other strobe is a fresh request.

Top module: `dm_backoff_tracker`

## Requirements
- R1: While reset is asserted, the following outputs are all low: lm_ready, beat_count, rd_retained, pci_wr_valid and pci_rd_req.
- R2: lm_ready is low in every cycle where bus_grant is high.
- R3: Write beats are accepted only at a clock edge where lm_ready is high.
  - lm_ready high already implies that the grant is low.
  - Each accepted beat appears exactly once on pci_wr_data, in the order of acceptance.
  - pci_wr_data holds while pci_wr_valid is high and pci_wr_ready is low.
  - beat_count rises by one for each accepted beat.
- R4: A grant during an active transfer ends that transfer. From the grant cycle on, lm_ready stays low until the master issues a new strobe.
- R5: A strobe in BACKOFF whose address equals the stored address, with lm_write=1, resumes the stored write.
  - beat_count keeps its value.
  - The next data taken is the first unaccepted beat.
  - The transfer ends after the stored length in total.
- R6: The write FIFO holds 8 entries. While it is full, lm_ready stays low during a write until an entry drains.
- R7: During a read, pci_rd_req is high until the stored length of beats has been fetched.
  - pci_rd_addr equals the request address plus the number of beats fetched so far, counted in beat units.
  - A beat is taken in a cycle where pci_rd_req and pci_rd_valid are both high.
  - Fetching continues in BACKOFF.
- R8: Read beats come out on lm_rdata in address order. lm_ready is high only for a beat that has been fetched and not yet delivered.
- R9: rd_retained is high in BACKOFF when a read has fetched beats that have not been delivered.
  - A strobe with the same address and lm_write=0 resumes delivery from the first undelivered beat.
  - Beats already fetched are not requested again.
- R10: A strobe in BACKOFF that differs in address or direction discards the kept data.
  - rd_retained and beat_count become 0.
  - A read request fetches again from its own address.
- R11: After the last beat of a transfer the block is idle.
  - lm_ready is low.
  - beat_count holds the transfer length until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lm_strobe | input | 1 | Address strobe from the local master, one cycle |
| lm_addr | input | AW | Transfer start address, in beat units |
| lm_write | input | 1 | 1 = write, 0 = read |
| lm_len | input | CW | Beats in the transfer, 1 to MAX_LEN |
| lm_wdata | input | DW | Write data for the current beat |
| lm_rdata | output | DW | Read data for the current beat |
| lm_ready | output | 1 | Beat acknowledge to the local master |
| bus_grant | input | 1 | Local bus granted to the bridge for an inbound access (backoff) |
| pci_wr_valid | output | 1 | Write FIFO has a beat for the PCI side |
| pci_wr_data | output | DW | Head of the write FIFO |
| pci_wr_ready | input | 1 | PCI side takes the head beat |
| pci_rd_req | output | 1 | Read beat requested from the PCI side |
| pci_rd_addr | output | AW | Address of the requested read beat |
| pci_rd_valid | input | 1 | PCI side returns the requested beat |
| pci_rd_data | input | DW | Returned read beat |
| beat_count | output | CW | Beats accepted (write) or delivered (read) in the current transfer |
| rd_retained | output | 1 | Fetched, undelivered read data is held during backoff |

## Verification
The bench raises the grant partway through a write. It then checks that the resumed strobe neither repeats nor skips a beat on the PCI side; a counter that lost or re-counted its place would push a duplicate or drop data. It interrupts a read after its beats were fetched and checks two things on a matching repeat: delivery continues in order, and the fetch count stays at the burst length, where a tracker that dropped its buffer would fetch again. A mismatching repeat must clear the kept data and fetch from the new address, or stale beats would come out. The bench also fills the FIFO with the drain stopped, where a design ignoring fullness would acknowledge beats it cannot store, and it slows the PCI stub so that a ready that runs ahead of fetched data returns wrong words.

// File: rtl/dmbt_pkg.sv
package dmbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_READ    = 2'd2,
        ST_BACKOFF = 2'd3
    } dmbt_state_e;

endpackage

// File: rtl/dmbt_wfifo.sv
module dmbt_wfifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic          full,
    output logic          valid,
    output logic [DW-1:0] dout
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]   mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [CNTW-1:0] count;
    logic            push_ok;
    logic            pop_ok;

    assign full    = (count == CNTW'(DEPTH));
    assign valid   = (count != '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && valid;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
        end
    end

endmodule

// File: rtl/dmbt_rbuf.sv
module dmbt_rbuf #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(i))) begin
                slot[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/dm_backoff_tracker.sv
module dm_backoff_tracker
    import dmbt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 32,
    parameter int WF_DEPTH = 8,
    parameter int MAX_LEN  = 8,
    localparam int CW      = $clog2(MAX_LEN + 1),
    localparam int IW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lm_strobe,
    input  logic [AW-1:0] lm_addr,
    input  logic          lm_write,
    input  logic [CW-1:0] lm_len,
    input  logic [DW-1:0] lm_wdata,
    output logic [DW-1:0] lm_rdata,
    output logic          lm_ready,
    input  logic          bus_grant,
    output logic          pci_wr_valid,
    output logic [DW-1:0] pci_wr_data,
    input  logic          pci_wr_ready,
    output logic          pci_rd_req,
    output logic [AW-1:0] pci_rd_addr,
    input  logic          pci_rd_valid,
    input  logic [DW-1:0] pci_rd_data,
    output logic [CW-1:0] beat_count,
    output logic          rd_retained
);

    dmbt_state_e   state;
    dmbt_state_e   nxt;

    logic [AW-1:0] req_addr;
    logic          req_write_q;
    logic [CW-1:0] req_len;
    logic [CW-1:0] xfer_cnt;
    logic [CW-1:0] fetch_cnt;

    logic          wf_full;
    logic          strobe_ok;
    logic          resume;
    logic          fresh;
    logic          beat;
    logic          last_beat;
    logic          fetch_hs;

    // Request decode: strobes are honoured only between transfers.
    assign strobe_ok = lm_strobe && ((state == ST_IDLE) || (state == ST_BACKOFF));
    assign resume    = strobe_ok && (state == ST_BACKOFF)
                       && (lm_addr == req_addr) && (lm_write == req_write_q);
    assign fresh     = strobe_ok && !resume;
    assign beat      = lm_ready;
    assign last_beat = beat && (xfer_cnt == req_len - CW'(1));
    assign fetch_hs  = pci_rd_req && pci_rd_valid;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (lm_strobe) begin
                    nxt = lm_write ? ST_WRITE : ST_READ;
                end
            end
            ST_WRITE, ST_READ: begin
                if (bus_grant) begin
                    nxt = ST_BACKOFF;
                end else if (last_beat) begin
                    nxt = ST_IDLE;
                end
            end
            ST_BACKOFF: begin
                if (lm_strobe) begin
                    nxt = lm_write ? ST_WRITE : ST_READ;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Stored request and progress counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr    <= '0;
            req_write_q <= 1'b1;
            req_len     <= '0;
            xfer_cnt    <= '0;
            fetch_cnt   <= '0;
        end else if (fresh) begin
            req_addr    <= lm_addr;
            req_write_q <= lm_write;
            req_len     <= lm_len;
            xfer_cnt    <= '0;
            fetch_cnt   <= '0;
        end else begin
            if (beat) begin
                xfer_cnt <= xfer_cnt + CW'(1);
            end
            if (fetch_hs) begin
                fetch_cnt <= fetch_cnt + CW'(1);
            end
        end
    end

    // Outputs: acknowledge gating and PCI read request
    always_comb begin
        lm_ready   = 1'b0;
        pci_rd_req = 1'b0;
        unique case (state)
            ST_IDLE: begin
                lm_ready = 1'b0;
            end
            ST_WRITE: begin
                lm_ready = !bus_grant && !wf_full;
            end
            ST_READ: begin
                lm_ready   = !bus_grant && (xfer_cnt < fetch_cnt);
                pci_rd_req = (fetch_cnt < req_len);
            end
            ST_BACKOFF: begin
                pci_rd_req = !req_write_q && (fetch_cnt < req_len);
            end
            default: begin
                lm_ready   = 1'b0;
                pci_rd_req = 1'b0;
            end
        endcase
    end

    assign pci_rd_addr = req_addr + AW'(fetch_cnt);
    assign beat_count  = xfer_cnt;
    assign rd_retained = (state == ST_BACKOFF) && !req_write_q && (fetch_cnt > xfer_cnt);

    dmbt_wfifo #(
        .DW   (DW),
        .DEPTH(WF_DEPTH)
    ) u_wfifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (beat && (state == ST_WRITE)),
        .din  (lm_wdata),
        .pop  (pci_wr_ready),
        .full (wf_full),
        .valid(pci_wr_valid),
        .dout (pci_wr_data)
    );

    dmbt_rbuf #(
        .DW   (DW),
        .DEPTH(MAX_LEN)
    ) u_rbuf (
        .clk    (clk),
        .wr_en  (fetch_hs),
        .wr_idx (fetch_cnt[IW-1:0]),
        .wr_data(pci_rd_data),
        .rd_idx (xfer_cnt[IW-1:0]),
        .rd_data(lm_rdata)
    );

endmodule

// File: rtl/dmbt_checker.sv
module dmbt_checker #(
    parameter int DW = 32,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lm_strobe,
    input logic          lm_ready,
    input logic          bus_grant,
    input logic [CW-1:0] beat_count,
    input logic          pci_wr_valid,
    input logic          pci_wr_ready,
    input logic [DW-1:0] pci_wr_data,
    input logic          rd_retained,
    input logic          wf_full,
    input logic          req_write_q
);

    // R2: no acknowledge while the bus is granted away
    p_ready_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lm_ready |-> !bus_grant);

    // R4: a grant without a new strobe leaves the master unacknowledged next cycle
    p_grant_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && !lm_strobe) |=> !lm_ready);

    // R3: the count moves only on an acknowledged beat
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lm_ready && !lm_strobe) |=> $stable(beat_count));

    // R3: each acknowledged beat advances the count by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lm_ready |=> (beat_count == $past(beat_count) + CW'(1)));

    // R3: the FIFO head holds while the PCI side stalls
    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_wr_valid && !pci_wr_ready) |=> (pci_wr_valid && $stable(pci_wr_data)));

    // R6: a full FIFO blocks write acknowledges
    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_full && req_write_q) |-> !lm_ready);

    // R9: kept read data is only reported while no beat is delivered
    p_retained_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_retained |-> !lm_ready);

endmodule

bind dm_backoff_tracker dmbt_checker u_dmbt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lm_strobe   (lm_strobe),
    .lm_ready    (lm_ready),
    .bus_grant   (bus_grant),
    .beat_count  (beat_count),
    .pci_wr_valid(pci_wr_valid),
    .pci_wr_ready(pci_wr_ready),
    .pci_wr_data (pci_wr_data),
    .rd_retained (rd_retained),
    .wf_full     (wf_full),
    .req_write_q (req_write_q)
);

// File: tb/dm_backoff_tracker_bench.sv
module dm_backoff_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lm_strobe;
    logic [31:0] lm_addr;
    logic        lm_write;
    logic [3:0]  lm_len;
    logic [31:0] lm_wdata;
    logic [31:0] lm_rdata;
    logic        lm_ready;
    logic        bus_grant;
    logic        pci_wr_valid;
    logic [31:0] pci_wr_data;
    logic        pci_wr_ready;
    logic        pci_rd_req;
    logic [31:0] pci_rd_addr;
    logic        pci_rd_valid;
    logic [31:0] pci_rd_data;
    logic [3:0]  beat_count;
    logic        rd_retained;

    logic        rd_slow;
    logic        phase;
    logic        rd_active;

    int          n_chk;
    int          n_fail;
    int          grant_viol;
    int          fetch_hs_cnt;
    logic [31:0] exp_wq[$];
    logic [31:0] exp_rq[$];
    logic [31:0] fetch_addr_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) phase <= ~phase;

    // PCI read stub: answers a request in the same cycle, or every other cycle when slowed
    assign pci_rd_valid = pci_rd_req && (!rd_slow || phase);
    assign pci_rd_data  = {8'hD0, pci_rd_addr[23:0]};

    dm_backoff_tracker u_dm_backoff_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .lm_strobe   (lm_strobe),
        .lm_addr     (lm_addr),
        .lm_write    (lm_write),
        .lm_len      (lm_len),
        .lm_wdata    (lm_wdata),
        .lm_rdata    (lm_rdata),
        .lm_ready    (lm_ready),
        .bus_grant   (bus_grant),
        .pci_wr_valid(pci_wr_valid),
        .pci_wr_data (pci_wr_data),
        .pci_wr_ready(pci_wr_ready),
        .pci_rd_req  (pci_rd_req),
        .pci_rd_addr (pci_rd_addr),
        .pci_rd_valid(pci_rd_valid),
        .pci_rd_data (pci_rd_data),
        .beat_count  (beat_count),
        .rd_retained (rd_retained)
    );

    function automatic logic [31:0] wdat(input logic [31:0] a, input int k);
        return a ^ (32'(k) * 32'h0101_0101) ^ 32'h5A00_0000;
    endfunction

    function automatic logic [31:0] rdat(input logic [31:0] a);
        return {8'hD0, a[23:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: compares PCI-side writes and local read returns with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (lm_ready && bus_grant) grant_viol++;
                if (pci_wr_valid && pci_wr_ready) begin
                    if (exp_wq.size() == 0) begin
                        chk(1'b0, "R3", "unexpected pci write", pci_wr_data, 32'h0);
                    end else begin
                        logic [31:0] e;
                        e = exp_wq.pop_front();
                        chk(pci_wr_data == e, "R3", "pci write order", pci_wr_data, e);
                    end
                end
                if (pci_rd_req && pci_rd_valid) begin
                    fetch_hs_cnt++;
                    fetch_addr_q.push_back(pci_rd_addr);
                end
                if (rd_active && lm_ready) begin
                    if (exp_rq.size() == 0) begin
                        chk(1'b0, "R8", "unexpected read beat", lm_rdata, 32'h0);
                    end else begin
                        logic [31:0] e;
                        e = exp_rq.pop_front();
                        chk(lm_rdata == e, "R8", "read data order", lm_rdata, e);
                    end
                end
            end
        end
    end

    // Write driver; all waits end on a falling edge
    task automatic wr_xfer(input logic [31:0] addr, input int len, input int bo_at,
                           input int bo_cycles, input int full_hold);
        int k;
        bit bo_done;
        int guard;
        k = 0;
        guard = 0;
        bo_done = (bo_at < 0);
        lm_strobe = 1'b1;
        lm_addr   = addr;
        lm_write  = 1'b1;
        lm_len    = 4'(len);
        lm_wdata  = wdat(addr, 0);
        @(negedge clk);
        lm_strobe = 1'b0;
        for (int h = 0; h < full_hold; h++) begin
            #1 chk(!lm_ready, "R6", "ready while fifo full", 32'(lm_ready), 32'h0);
            @(negedge clk);
        end
        if (full_hold > 0) pci_wr_ready = 1'b1;
        while (k < len && guard < 400) begin
            guard++;
            if (!bo_done && k == bo_at) begin
                bus_grant = 1'b1;
                #1 chk(!lm_ready, "R2", "ready with grant (write)", 32'(lm_ready), 32'h0);
                @(negedge clk);
                for (int c = 1; c < bo_cycles; c++) begin
                    #1 chk(!lm_ready, "R2", "ready with grant held", 32'(lm_ready), 32'h0);
                    @(negedge clk);
                end
                bus_grant = 1'b0;
                for (int c = 0; c < 3; c++) begin
                    #1 chk(!lm_ready, "R4", "ready after backoff before strobe", 32'(lm_ready), 32'h0);
                    @(negedge clk);
                end
                chk(beat_count == 4'(k), "R3", "accepted count at backoff", 32'(beat_count), 32'(k));
                lm_strobe = 1'b1;
                lm_wdata  = wdat(addr, k);
                @(negedge clk);
                lm_strobe = 1'b0;
                chk(beat_count == 4'(k), "R5", "count kept on resume", 32'(beat_count), 32'(k));
                bo_done = 1'b1;
            end
            lm_wdata = wdat(addr, k);
            #1;
            if (lm_ready) begin
                exp_wq.push_back(wdat(addr, k));
                k++;
            end
            @(negedge clk);
        end
        #1;
        chk(!lm_ready, "R11", "ready after write end", 32'(lm_ready), 32'h0);
        chk(beat_count == 4'(len), "R5", "write total beats", 32'(beat_count), 32'(len));
        @(negedge clk);
    endtask

    // Read driver; rst_addr differing from addr makes the resume strobe a mismatch
    task automatic rd_xfer(input logic [31:0] addr, input int len, input int bo_at,
                           input logic [31:0] rst_addr, input int rst_len);
        int k;
        bit bo_done;
        int guard;
        int cur_len;
        logic [31:0] cur_addr;
        k = 0;
        guard = 0;
        bo_done = (bo_at < 0);
        cur_len = len;
        cur_addr = addr;
        fetch_hs_cnt = 0;
        fetch_addr_q.delete();
        for (int i = 0; i < len; i++) exp_rq.push_back(rdat(addr + 32'(i)));
        rd_active = 1'b1;
        lm_strobe = 1'b1;
        lm_addr   = addr;
        lm_write  = 1'b0;
        lm_len    = 4'(len);
        @(negedge clk);
        lm_strobe = 1'b0;
        while (k < cur_len && guard < 400) begin
            guard++;
            if (!bo_done && k == bo_at) begin
                bus_grant = 1'b1;
                #1 chk(!lm_ready, "R2", "ready with grant (read)", 32'(lm_ready), 32'h0);
                @(negedge clk);
                bus_grant = 1'b0;
                for (int c = 0; c < 10; c++) begin
                    #1 chk(!lm_ready, "R4", "read ready during backoff", 32'(lm_ready), 32'h0);
                    @(negedge clk);
                end
                chk(rd_retained, "R9", "retained flag in backoff", 32'(rd_retained), 32'h1);
                chk(fetch_hs_cnt == len, "R7", "fetch continues in backoff", 32'(fetch_hs_cnt), 32'(len));
                lm_strobe = 1'b1;
                lm_addr   = rst_addr;
                lm_len    = 4'(rst_len);
                if (rst_addr != addr) begin
                    exp_rq.delete();
                    for (int i = 0; i < rst_len; i++) exp_rq.push_back(rdat(rst_addr + 32'(i)));
                    fetch_hs_cnt = 0;
                    fetch_addr_q.delete();
                    cur_len = rst_len;
                    cur_addr = rst_addr;
                    k = 0;
                end
                @(negedge clk);
                lm_strobe = 1'b0;
                if (rst_addr != addr) begin
                    chk(!rd_retained, "R10", "retained cleared on mismatch", 32'(rd_retained), 32'h0);
                    chk(beat_count == 4'd0, "R10", "count cleared on mismatch", 32'(beat_count), 32'h0);
                end else begin
                    chk(beat_count == 4'(k), "R9", "delivered count kept", 32'(beat_count), 32'(k));
                end
                bo_done = 1'b1;
            end
            #1;
            if (lm_ready) k++;
            @(negedge clk);
        end
        #1;
        chk(!lm_ready, "R11", "ready after read end", 32'(lm_ready), 32'h0);
        chk(beat_count == 4'(cur_len), "R11", "count holds length", 32'(beat_count), 32'(cur_len));
        chk(fetch_hs_cnt == cur_len, "R9", "no refetch of held beats", 32'(fetch_hs_cnt), 32'(cur_len));
        for (int i = 0; i < cur_len && i < fetch_addr_q.size(); i++) begin
            chk(fetch_addr_q[i] == cur_addr + 32'(i), "R7", "fetch address sequence",
                fetch_addr_q[i], cur_addr + 32'(i));
        end
        chk(exp_rq.size() == 0, "R8", "all read beats delivered", 32'(exp_rq.size()), 32'h0);
        rd_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        n_chk = 0; n_fail = 0; grant_viol = 0; fetch_hs_cnt = 0;
        phase = 1'b0; rd_slow = 1'b0; rd_active = 1'b0;
        rst_n = 1'b0; lm_strobe = 1'b0; lm_addr = '0; lm_write = 1'b0;
        lm_len = '0; lm_wdata = '0; bus_grant = 1'b0; pci_wr_ready = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk(!lm_ready, "R1", "reset ready", 32'(lm_ready), 32'h0);
        chk(beat_count == 4'd0, "R1", "reset count", 32'(beat_count), 32'h0);
        chk(!rd_retained, "R1", "reset retained", 32'(rd_retained), 32'h0);
        chk(!pci_wr_valid, "R1", "reset wr valid", 32'(pci_wr_valid), 32'h0);
        chk(!pci_rd_req, "R1", "reset rd req", 32'(pci_rd_req), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Plain write, then write interrupted after 3 beats (R3, R5)
        wr_xfer(32'h0000_1000, 5, -1, 0, 0);
        wr_xfer(32'h0000_2000, 7, 3, 2, 0);
        // Backoff before the first beat
        wr_xfer(32'h0000_2400, 2, 0, 1, 0);

        // Fill the FIFO with drain stopped, then block the next write (R6)
        repeat (12) @(negedge clk);
        pci_wr_ready = 1'b0;
        wr_xfer(32'h0000_3000, 8, -1, 0, 0);
        wr_xfer(32'h0000_3100, 3, -1, 0, 4);
        repeat (20) @(negedge clk);
        chk(exp_wq.size() == 0, "R3", "all writes drained", 32'(exp_wq.size()), 32'h0);

        // Reads: plain, slow stub, matching resume, mismatching resume
        rd_xfer(32'h0000_4000, 4, -1, 32'h0, 0);
        rd_slow = 1'b1;
        rd_xfer(32'h0000_4800, 5, -1, 32'h0, 0);
        rd_slow = 1'b0;
        rd_xfer(32'h0000_5000, 6, 2, 32'h0000_5000, 6);
        rd_xfer(32'h0000_6000, 4, 1, 32'h0000_7000, 3);

        chk(grant_viol == 0, "R2", "ready seen with grant", 32'(grant_viol), 32'h0);
        report();
        $finish;
    end

endmodule